// File: doc/BRIEF.md
# Multi-digit BCD adder-subtractor

This block is an arithmetic unit for unsigned packed decimal numbers. Each operand holds DIGITS decimal digits, and each digit is four bits wide. The block can add the two operands. It can also subtract the second operand from the first, and it then returns the result in sign-magnitude form. Every digit stage first adds in plain binary. When the binary digit sum is above nine, or the 4-bit add carries, the stage adds six to correct the digit and passes a decimal carry to the stage above. The carries ripple from the least significant digit up to the most significant one.

To subtract, the block builds the ten's complement of the subtrahend. It replaces each subtrahend digit by nine minus that digit and injects a carry of one into the lowest stage. A carry out of the top stage means the minuend is at least as large as the subtrahend, so the sum is already the answer. With no such carry, the answer is negative. The block then sets the sign flag and returns the ten's complement of the raw sum as the magnitude. The block also flags any operand digit coded 10 to 15. Operands are taken in with `in_valid`, and the registered result appears one clock later, marked by `out_valid`.

Top module: `bcd_addsub`

## Requirements
- R1: With `mode`=0 (add), `result` equals (A + B) mod 10^DIGITS, where each 4-bit field of bits [4k+3:4k] holds decimal digit k and digit 0 is the least significant.
- R2: In add mode, `carry` is 1 exactly when A + B is 10^DIGITS or more.
- R3: With `mode`=1 (subtract) and A ≥ B, `result` equals A − B, `neg` is 0 and `carry` is 1.
- R4: With `mode`=1 and A < B, `result` equals B − A, `neg` is 1 and `carry` is 0.
- R5: A subtraction of equal operands gives `result` 0 with `neg` 0.
- R6: `neg` is never 1 for an add, and the same operands give different outputs depending on `mode`.
- R7: `err` is 1 when any digit of A or B holds a code from 10 to 15, and 0 when all digits are 0 to 9.
- R8: `out_valid` is 1 in the clock after a cycle with `in_valid` high, and 0 otherwise. The registered outputs keep their values while `in_valid` is low, even when the operands change.
- R9: During reset and right after it, `out_valid`, `result`, `neg`, `carry` and `err` are all 0.
- R10: When `err` is 0, every result digit on a valid output lies between 0 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Capture the operands and the mode on this clock |
| mode | input | 1 | 0 = add, 1 = subtract (A − B) |
| op_a | input | 4*DIGITS | Operand A, packed BCD |
| op_b | input | 4*DIGITS | Operand B, packed BCD |
| out_valid | output | 1 | The registered result is new this cycle |
| result | output | 4*DIGITS | BCD sum, or the magnitude of the difference |
| neg | output | 1 | The difference is negative |
| carry | output | 1 | Decimal end carry of the top digit |
| err | output | 1 | An operand digit held an illegal code |

## Verification
The assertions assume that `in_valid` stays low until the internal reset synchroniser has released. The bench waits several cycles after deasserting `rst_n` before it sends any operands. The digit-range property only holds for legal operands, so it is qualified by `err`. The illegal-code cases are confined to the scenarios that check `err`. Each operation holds `in_valid` for exactly one cycle, so every output cycle can be tied to a single input cycle.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } bcd_op_e;

  function automatic logic digit_bad(input logic [DIGIT_W-1:0] d);
    return d > DIGIT_MAX;
  endfunction
endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_addsub_pkg::*;
(
  input  logic [DIGIT_W-1:0] x,
  input  logic [DIGIT_W-1:0] y,
  input  logic               ci,
  output logic [DIGIT_W-1:0] s,
  output logic               co
);
  logic [DIGIT_W:0] raw_sum;
  logic             fix;

  always_comb begin
    raw_sum = {1'b0, x} + {1'b0, y} + {{DIGIT_W{1'b0}}, ci};
    fix     = raw_sum > {1'b0, DIGIT_MAX};
    s       = fix ? (raw_sum[DIGIT_W-1:0] + 4'd6) : raw_sum[DIGIT_W-1:0];
    co      = fix;
  end
endmodule

// File: rtl/bcd_ripple.sv
module bcd_ripple
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * DIGIT_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [DIGITS:0] c;
  assign c[0] = ci;

  for (genvar k = 0; k < DIGITS; k++) begin : g_stage
    bcd_digit_stage u_stage (
      .x (x[k*DIGIT_W +: DIGIT_W]),
      .y (y[k*DIGIT_W +: DIGIT_W]),
      .ci(c[k]),
      .s (s[k*DIGIT_W +: DIGIT_W]),
      .co(c[k+1])
    );
  end

  assign co = c[DIGITS];
endmodule

// File: rtl/bcd_nines.sv
module bcd_nines
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * DIGIT_W
) (
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    assign q[k*DIGIT_W +: DIGIT_W] = DIGIT_MAX - d[k*DIGIT_W +: DIGIT_W];
  end
endmodule

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * DIGIT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         mode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         neg,
  output logic         carry,
  output logic         err
);
  logic         rst_i_n;
  logic [W-1:0] b_nines, b_eff, raw_sum, raw_nines, recomp;
  logic         end_c, unused_recomp_co;
  logic [2*DIGITS-1:0] bad_dig;

  logic [W-1:0] res_d, res_q;
  logic         neg_d, neg_q, car_d, car_q, err_d, err_q, vld_q;

  bcd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  bcd_nines #(.DIGITS(DIGITS)) u_nb (.d(op_b), .q(b_nines));

  assign b_eff = (bcd_op_e'(mode) == OP_SUB) ? b_nines : op_b;

  bcd_ripple #(.DIGITS(DIGITS)) u_main (
    .x(op_a), .y(b_eff), .ci(mode), .s(raw_sum), .co(end_c)
  );

  bcd_nines #(.DIGITS(DIGITS)) u_nr (.d(raw_sum), .q(raw_nines));

  bcd_ripple #(.DIGITS(DIGITS)) u_fix (
    .x(raw_nines), .y('0), .ci(1'b1), .s(recomp), .co(unused_recomp_co)
  );

  for (genvar k = 0; k < DIGITS; k++) begin : g_chk
    assign bad_dig[2*k]   = digit_bad(op_a[k*DIGIT_W +: DIGIT_W]);
    assign bad_dig[2*k+1] = digit_bad(op_b[k*DIGIT_W +: DIGIT_W]);
  end

  always_comb begin
    neg_d = (bcd_op_e'(mode) == OP_SUB) && !end_c;
    res_d = neg_d ? recomp : raw_sum;
    car_d = end_c;
    err_d = |bad_dig;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      neg_q <= 1'b0;
      car_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        neg_q <= neg_d;
        car_q <= car_d;
        err_q <= err_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign neg       = neg_q;
  assign carry     = car_q;
  assign err       = err_q;
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * DIGIT_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         mode,
  input logic [W-1:0] result,
  input logic         out_valid,
  input logic         neg,
  input logic         carry,
  input logic         err
);
  logic digits_ok;
  always_comb begin
    digits_ok = 1'b1;
    for (int k = 0; k < DIGITS; k++)
      if (result[k*DIGIT_W +: DIGIT_W] > DIGIT_MAX) digits_ok = 1'b0;
  end

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(neg) && $stable(carry) && $stable(err)));
  p_digit_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !err) |-> digits_ok);
  p_no_neg_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && neg) |-> (result != '0));
  p_add_never_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode) |=> !neg);
  p_neg_no_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && neg) |-> !carry);
endmodule

bind bcd_addsub bcd_addsub_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
  .result(result), .out_valid(out_valid), .neg(neg), .carry(carry), .err(err)
);

// File: tb/bcd_addsub_bench.sv
module bcd_addsub_bench;
  localparam int D   = 4;
  localparam int W   = 4 * D;
  localparam int MOD = 10000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         mode;
  logic [W-1:0] op_a, op_b;
  logic         out_valid, neg, carry, err;
  logic [W-1:0] result;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bcd_addsub #(.DIGITS(D)) u_bcd_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result),
    .neg(neg), .carry(carry), .err(err)
  );

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r = '0;
    int t = v;
    for (int k = 0; k < D; k++) begin
      r[k*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One operation on decimal values; checks value, sign, carry, error flag.
  task automatic run_op(input string req, input int a, input int b, input bit m);
    int exp_r; bit exp_n, exp_c;
    if (!m) begin
      exp_r = (a + b) % MOD; exp_c = (a + b) >= MOD; exp_n = 0;
    end else if (a >= b) begin
      exp_r = a - b; exp_c = 1; exp_n = 0;
    end else begin
      exp_r = b - a; exp_c = 0; exp_n = 1;
    end
    @(negedge clk);
    op_a = to_bcd(a); op_b = to_bcd(b); mode = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " out_valid"}, 32'(out_valid), 32'd1);
    chk({req, " result"}, 32'(result), 32'(to_bcd(exp_r)));
    chk({req, " neg"}, 32'(neg), 32'(exp_n));
    chk({req, " carry"}, 32'(carry), 32'(exp_c));
    chk({req, " err"}, 32'(err), 32'd0);
  endtask

  task automatic t_reset();
    chk("R9 out_valid", 32'(out_valid), 32'd0);
    chk("R9 result", 32'(result), 32'd0);
    chk("R9 neg/carry/err", 32'({neg, carry, err}), 32'd0);
  endtask

  task automatic t_add();
    run_op("R1 5+3", 5, 3, 1'b0);
    run_op("R1 8+5", 8, 5, 1'b0);
    run_op("R1 1234+5678", 1234, 5678, 1'b0);
    run_op("R1 999+1", 999, 1, 1'b0);
  endtask

  task automatic t_overflow();
    run_op("R2 9999+1", 9999, 1, 1'b0);
    run_op("R2 5000+5000", 5000, 5000, 1'b0);
    run_op("R2 9999+9999", 9999, 9999, 1'b0);
  endtask

  task automatic t_sub_pos();
    run_op("R3 7253-325", 7253, 325, 1'b1);
    run_op("R3 1000-1", 1000, 1, 1'b1);
    run_op("R3 9999-0", 9999, 0, 1'b1);
  endtask

  task automatic t_sub_neg();
    run_op("R4 325-7253", 325, 7253, 1'b1);
    run_op("R4 19-30", 19, 30, 1'b1);
    run_op("R4 0-9999", 0, 9999, 1'b1);
  endtask

  task automatic t_equal();
    run_op("R5 4321-4321", 4321, 4321, 1'b1);
    run_op("R5 0-0", 0, 0, 1'b1);
  endtask

  task automatic t_mode();
    logic [W-1:0] r_add;
    run_op("R6 add 20+70", 20, 70, 1'b0);
    r_add = result;
    run_op("R6 sub 20-70", 20, 70, 1'b1);
    chk("R6 mode changes result", 32'(result != r_add), 32'd1);
  endtask

  task automatic t_err();
    @(negedge clk);
    op_a = 16'h00A0; op_b = 16'h0001; mode = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 bad digit in A", 32'(err), 32'd1);
    @(negedge clk);
    op_a = 16'h0001; op_b = 16'hF000; mode = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 bad digit in B", 32'(err), 32'd1);
    run_op("R7 legal digits clear err", 9090, 909, 1'b0);
  endtask

  task automatic t_hold();
    logic [W-1:0] r0;
    run_op("R8 first", 4567, 1111, 1'b1);
    r0 = result;
    @(negedge clk);
    op_a = to_bcd(1); op_b = to_bcd(2); mode = 1'b0;
    chk("R8 out_valid drops", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk("R8 result held", 32'(result), 32'(r0));
    chk("R8 out_valid low", 32'(out_valid), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; mode = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_add();
    t_overflow();
    t_sub_pos();
    t_sub_neg();
    t_equal();
    t_mode();
    t_err();
    t_hold();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule